// File: doc/BRIEF.md
# Bus-Attached ROM/RAM Emulator

This block poses as the whole memory system of a small 8-bit microprocessor. The processor's active-low strobes (memory request, I/O request, read, write), its 8-bit address and its data bus arrive from outside. They are brought into a much faster local clock and decoded there. A memory read is answered with a byte from one of two 128-byte arrays. Address bit 7 chooses the array: 0 selects a read-only ROM and 1 selects a RAM. A memory write into the RAM half stores the bus byte. The data bus is split into an input, an output and an output-enable. The enable is raised only while a memory read is in progress and drops a fixed number of local cycles after the read strobe deasserts. This leaves the bus free for a push-pull processor to drive write data.

Two further outputs control an external bus transceiver. Its enable is raised only during a memory read or an I/O read. Its direction points toward the processor only during such a read. I/O cycles never touch either array. They are counted, and the address and data of the most recent one are captured. The ROM is filled through a separate synchronous port. That port accepts writes only while the processor is held in reset.

Top module: `mem_emu`

## Requirements
- R1: In the cycle after synchronous reset is released, data_oe, xcvr_en and xcvr_dir are 0. All four counters are 0.
- R2: A preload write (pl_we=1) stores pl_data into ROM location pl_addr only while cpu_hold=1. A preload write with cpu_hold=0 leaves the ROM unchanged.
- R3: A memory read (mreq_n=0, rd_n=0, iorq_n=1) returns ROM[addr[6:0]] on data_out while data_oe=1 if addr[7]=0. It returns RAM[addr[6:0]] if addr[7]=1. The address must be stable at least 2 cycles before the strobes fall.
- R4: data_oe rises on the 3rd rising clock edge after the read strobes are first seen low. It falls on the 3rd rising edge after rd_n returns high. This is 15 ns at a 5 ns clock and fits inside the processor's read window.
- R5: A memory write (mreq_n=0, wr_n=0) with addr[7]=1 stores data_in into RAM[addr[6:0]] when the qualified write ends. A later read returns the stored byte.
- R6: A memory write with addr[7]=0 leaves the ROM contents unchanged.
- R7: An I/O cycle (iorq_n=0 with rd_n or wr_n low) keeps data_oe at 0 and changes neither array.
- R8: xcvr_en and xcvr_dir are 1 only during a memory read or an I/O read, with the same latency as data_oe. During writes and idle they are 0.
- R9: cnt_mem_rd increments as each memory read begins. cnt_mem_wr, cnt_io_rd and cnt_io_wr each increment as a cycle of their kind ends. io_last_addr and io_last_data hold the address and data bus values of the most recent I/O cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local fast clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_hold | input | 1 | High while the processor is held in reset; enables preload |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | AW (8) | Processor address bus |
| data_in | input | DW (8) | Data bus as seen at the pins |
| data_out | output | DW (8) | Byte driven toward the processor |
| data_oe | output | 1 | Drive enable for data_out |
| xcvr_en | output | 1 | External transceiver enable |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward processor |
| pl_we | input | 1 | ROM preload write strobe |
| pl_addr | input | AW-1 (7) | ROM preload address |
| pl_data | input | DW (8) | ROM preload data |
| cnt_mem_rd | output | CNT_W (16) | Memory read count |
| cnt_mem_wr | output | CNT_W (16) | Memory write count |
| cnt_io_rd | output | CNT_W (16) | I/O read count |
| cnt_io_wr | output | CNT_W (16) | I/O write count |
| io_last_addr | output | AW (8) | Address of the latest I/O cycle |
| io_last_data | output | DW (8) | Data bus value of the latest I/O cycle |

## Verification
The hardest situation to reach is the release at the end of a read, followed at once by a write. The output enable must drop exactly three edges after rd_n rises, and no later. The bench ends each read by raising the strobes and samples data_oe on each of the following negative edges. It then starts a write directly afterwards and checks that nothing is driven. Writes aimed at the ROM half, and I/O cycles placed on addresses whose RAM content is known, are read back through normal memory reads to prove they changed nothing.

// File: rtl/mem_emu_pkg.sv
package mem_emu_pkg;
  // Kind of processor bus cycle as decoded from the synchronised strobes.
  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_MEM_RD = 3'd1,
    CYC_MEM_WR = 3'd2,
    CYC_IO_RD  = 3'd3,
    CYC_IO_WR  = 3'd4
  } cyc_e;

  // Event slots, in the order of the cycle kinds above.
  localparam int EV_MEM_RD = 0;
  localparam int EV_MEM_WR = 1;
  localparam int EV_IO_RD  = 2;
  localparam int EV_IO_WR  = 3;
  localparam int N_EV      = 4;
endpackage

// File: rtl/mem_emu_sync.sv
// Shift-register synchroniser / alignment delay of DEPTH stages.
module mem_emu_sync #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] stg;

  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) stg <= {DEPTH{RST_VAL}};
      else     stg <= d;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) stg <= {DEPTH{RST_VAL}};
      else     stg <= {stg[DEPTH-2:0], d};
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/mem_emu_decode.sv
// Classifies the synchronised strobes and produces one-cycle events.
module mem_emu_decode
  import mem_emu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      strb,      // {mreq_n, iorq_n, rd_n, wr_n}
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_data,
  output cyc_e            kind_now,
  output logic [N_EV-1:0] evt,
  output logic [AW-1:0]   lat_addr,
  output logic [DW-1:0]   lat_data
);
  logic mreq_n_s, iorq_n_s, rd_n_s, wr_n_s;
  cyc_e cur_kind;

  assign {mreq_n_s, iorq_n_s, rd_n_s, wr_n_s} = strb;

  always_comb begin
    if (!mreq_n_s && !rd_n_s)      kind_now = CYC_MEM_RD;
    else if (!mreq_n_s && !wr_n_s) kind_now = CYC_MEM_WR;
    else if (!iorq_n_s && !rd_n_s) kind_now = CYC_IO_RD;
    else if (!iorq_n_s && !wr_n_s) kind_now = CYC_IO_WR;
    else                           kind_now = CYC_IDLE;
  end

  // Reads are counted as they begin; the other kinds as they end, so the
  // latched bus values are final.
  for (genvar k = 0; k < N_EV; k++) begin : g_evt
    localparam cyc_e KIND = cyc_e'(k + 1);
    if (k == EV_MEM_RD) begin : g_start
      assign evt[k] = (kind_now == KIND) && (cur_kind != KIND);
    end else begin : g_done
      assign evt[k] = (cur_kind == KIND) && (kind_now != KIND);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_kind <= CYC_IDLE;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      cur_kind <= kind_now;
      if (kind_now != CYC_IDLE) begin
        lat_addr <= bus_addr;
        lat_data <= bus_data;
      end
    end
  end
endmodule

// File: rtl/mem_emu_store.sv
// ROM and RAM halves, each a simple dual-port array with synchronous read.
module mem_emu_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-2:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pl_en,
  input  logic [AW-2:0] pl_addr,
  input  logic [DW-1:0] pl_data,
  output logic [DW-1:0] rd_q
);
  localparam int IW    = AW - 1;
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] rom [DEPTH];
  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] rom_q, ram_q;
  logic          sel_ram;

  always_ff @(posedge clk) begin
    if (pl_en) rom[pl_addr] <= pl_data;
    rom_q <= rom[rd_addr[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= wr_data;
    ram_q <= ram[rd_addr[IW-1:0]];
  end

  always_ff @(posedge clk) sel_ram <= rd_addr[AW-1];

  assign rd_q = sel_ram ? ram_q : rom_q;
endmodule

// File: rtl/mem_emu_stats.sv
// One wrapping counter per event slot.
module mem_emu_stats
  import mem_emu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_EV-1:0]         evt,
  output logic [N_EV*CNT_W-1:0]   cnt_flat
);
  for (genvar k = 0; k < N_EV; k++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)         cnt <= '0;
      else if (evt[k]) cnt <= cnt + 1'b1;
    end
    assign cnt_flat[k*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/mem_emu.sv
module mem_emu
  import mem_emu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CNT_W = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_hold,
  input  logic             mreq_n,
  input  logic             iorq_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data_in,
  output logic [DW-1:0]    data_out,
  output logic             data_oe,
  output logic             xcvr_en,
  output logic             xcvr_dir,
  input  logic             pl_we,
  input  logic [AW-2:0]    pl_addr,
  input  logic [DW-1:0]    pl_data,
  output logic [CNT_W-1:0] cnt_mem_rd,
  output logic [CNT_W-1:0] cnt_mem_wr,
  output logic [CNT_W-1:0] cnt_io_rd,
  output logic [CNT_W-1:0] cnt_io_wr,
  output logic [AW-1:0]    io_last_addr,
  output logic [DW-1:0]    io_last_data
);
  localparam int IW = AW - 1;
  localparam int BW = AW + DW;

  logic [3:0]            strb_s;
  logic [BW-1:0]         bus_s;
  cyc_e                  kind_now;
  logic [N_EV-1:0]       evt;
  logic [AW-1:0]         lat_addr;
  logic [DW-1:0]         lat_data;
  logic [DW-1:0]         rd_q;
  logic [N_EV*CNT_W-1:0] cnt_flat;

  // Strobes go through the synchroniser; address/data ride an equal delay
  // so they stay aligned with the decoded cycle.
  mem_emu_sync #(.W(4), .DEPTH(SYNC_DEPTH), .RST_VAL(4'hF)) u_ssync (
    .clk(clk), .rst(rst), .d({mreq_n, iorq_n, rd_n, wr_n}), .q(strb_s)
  );

  mem_emu_sync #(.W(BW), .DEPTH(SYNC_DEPTH), .RST_VAL('0)) u_bsync (
    .clk(clk), .rst(rst), .d({addr, data_in}), .q(bus_s)
  );

  mem_emu_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .strb(strb_s),
    .bus_addr(bus_s[BW-1:DW]), .bus_data(bus_s[DW-1:0]),
    .kind_now(kind_now), .evt(evt), .lat_addr(lat_addr), .lat_data(lat_data)
  );

  mem_emu_store #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk),
    .rd_addr(bus_s[BW-1:DW]),
    .wr_en(evt[EV_MEM_WR] & lat_addr[AW-1]),
    .wr_addr(lat_addr[IW-1:0]),
    .wr_data(lat_data),
    .pl_en(cpu_hold & pl_we),
    .pl_addr(pl_addr),
    .pl_data(pl_data),
    .rd_q(rd_q)
  );

  mem_emu_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .evt(evt), .cnt_flat(cnt_flat)
  );

  assign cnt_mem_rd = cnt_flat[EV_MEM_RD*CNT_W +: CNT_W];
  assign cnt_mem_wr = cnt_flat[EV_MEM_WR*CNT_W +: CNT_W];
  assign cnt_io_rd  = cnt_flat[EV_IO_RD*CNT_W +: CNT_W];
  assign cnt_io_wr  = cnt_flat[EV_IO_WR*CNT_W +: CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out     <= '0;
      data_oe      <= 1'b0;
      xcvr_en      <= 1'b0;
      xcvr_dir     <= 1'b0;
      io_last_addr <= '0;
      io_last_data <= '0;
    end else begin
      data_out <= rd_q;
      data_oe  <= (kind_now == CYC_MEM_RD);
      xcvr_en  <= (kind_now == CYC_MEM_RD) || (kind_now == CYC_IO_RD);
      xcvr_dir <= (kind_now == CYC_MEM_RD) || (kind_now == CYC_IO_RD);
      if (evt[EV_IO_RD] || evt[EV_IO_WR]) begin
        io_last_addr <= lat_addr;
        io_last_data <= lat_data;
      end
    end
  end
endmodule

// File: rtl/mem_emu_checker.sv
module mem_emu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             data_oe,
  input logic             xcvr_en,
  input logic             xcvr_dir,
  input logic [CNT_W-1:0] cnt_mem_rd,
  input logic [CNT_W-1:0] cnt_io_wr
);
  // R1: one cycle after reset the bus is released and the read count is clear
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!data_oe && !xcvr_en && cnt_mem_rd == '0));

  // R8: driving the bus implies the transceiver is open toward the processor
  p_oe_xcvr_r8: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (xcvr_en && xcvr_dir));

  // R8: with the transceiver disabled, direction rests at "from processor"
  p_dir_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !xcvr_en |-> !xcvr_dir);

  // R9: each new read drive coincides with one read count step
  p_rd_cnt_on_oe_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> cnt_mem_rd == CNT_W'($past(cnt_mem_rd) + 1'b1));

  // R9: the I/O write count only ever moves by one
  p_iowr_step_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_io_wr != $past(cnt_io_wr)) |-> cnt_io_wr == CNT_W'($past(cnt_io_wr) + 1'b1));
endmodule

bind mem_emu mem_emu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .data_oe(data_oe), .xcvr_en(xcvr_en),
  .xcvr_dir(xcvr_dir), .cnt_mem_rd(cnt_mem_rd), .cnt_io_wr(cnt_io_wr)
);

// File: tb/mem_emu_test.sv
`timescale 1ns/1ps
module mem_emu_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, cpu_hold = 1'b1;
  logic mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] addr = '0, data_in = '0, data_out;
  logic data_oe, xcvr_en, xcvr_dir;
  logic pl_we = 1'b0;
  logic [6:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic [CW-1:0] cnt_mem_rd, cnt_mem_wr, cnt_io_rd, cnt_io_wr;
  logic [7:0] io_last_addr, io_last_data;

  mem_emu uut (
    .clk(clk), .rst(rst), .cpu_hold(cpu_hold),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .xcvr_en(xcvr_en), .xcvr_dir(xcvr_dir),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .cnt_mem_rd(cnt_mem_rd), .cnt_mem_wr(cnt_mem_wr),
    .cnt_io_rd(cnt_io_rd), .cnt_io_wr(cnt_io_wr),
    .io_last_addr(io_last_addr), .io_last_data(io_last_data)
  );

  int errors = 0, checks = 0;
  int exp_mrd = 0, exp_mwr = 0, exp_iord = 0, exp_iowr = 0;
  logic [7:0] exp_ioa = '0, exp_iod = '0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] val; string req; } item_t;
  item_t sb[$];

  function automatic logic [7:0] rom_val(int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ncyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: on the first cycle of each read drive, compare against the queue.
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (data_oe && !oe_prev) begin
      if (sb.size() == 0) chk(1'b0, "R3 unexpected drive", {24'd0, data_out}, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(data_out == it.val, it.req, {24'd0, data_out}, {24'd0, it.val});
      end
    end
    oe_prev = data_oe;
  end

  // R3/R4: memory read with timing of drive and release
  task automatic mem_read(logic [7:0] a, logic [7:0] e, string req);
    item_t it;
    addr = a;
    ncyc(2);
    it.val = e; it.req = req;
    sb.push_back(it);
    mreq_n = 0; rd_n = 0;
    ncyc(2);
    chk(data_oe == 1'b0, "R4 early drive", {31'd0, data_oe}, 0);
    ncyc(1);
    chk(data_oe == 1'b1, "R4 drive latency", {31'd0, data_oe}, 1);
    chk(xcvr_en && xcvr_dir, "R8 read xcvr", {30'd0, xcvr_en, xcvr_dir}, 3);
    ncyc(2);
    mreq_n = 1; rd_n = 1;
    ncyc(2);
    chk(data_oe == 1'b1, "R4 release too early", {31'd0, data_oe}, 1);
    ncyc(1);
    chk(data_oe == 1'b0, "R4 release", {31'd0, data_oe}, 0);
    exp_mrd++;
  endtask

  task automatic mem_write(logic [7:0] a, logic [7:0] d);
    addr = a; data_in = d;
    mreq_n = 0; wr_n = 0;
    ncyc(4);
    chk(!xcvr_en && !xcvr_dir && !data_oe, "R8 write xcvr", {29'd0, xcvr_en, xcvr_dir, data_oe}, 0);
    mreq_n = 1; wr_n = 1;
    ncyc(4);
    exp_mwr++;
  endtask

  task automatic io_cycle(bit is_rd, logic [7:0] a, logic [7:0] d);
    addr = a; data_in = d;
    iorq_n = 0;
    if (is_rd) rd_n = 0; else wr_n = 0;
    ncyc(4);
    chk(data_oe == 1'b0, "R7 io drive", {31'd0, data_oe}, 0);
    chk(xcvr_en == is_rd && xcvr_dir == is_rd, "R8 io xcvr",
        {30'd0, xcvr_en, xcvr_dir}, is_rd ? 3 : 0);
    iorq_n = 1; rd_n = 1; wr_n = 1;
    ncyc(4);
    if (is_rd) exp_iord++; else exp_iowr++;
    exp_ioa = a; exp_iod = d;
  endtask

  task automatic check_counts();
    chk(cnt_mem_rd == CW'(exp_mrd), "R9 mem rd count", 32'(cnt_mem_rd), exp_mrd);
    chk(cnt_mem_wr == CW'(exp_mwr), "R9 mem wr count", 32'(cnt_mem_wr), exp_mwr);
    chk(cnt_io_rd == CW'(exp_iord), "R9 io rd count", 32'(cnt_io_rd), exp_iord);
    chk(cnt_io_wr == CW'(exp_iowr), "R9 io wr count", 32'(cnt_io_wr), exp_iowr);
  endtask

  initial begin
    ncyc(3);
    rst = 0;
    ncyc(1);
    // R1
    chk(!data_oe && !xcvr_en && !xcvr_dir, "R1 outputs", {29'd0, data_oe, xcvr_en, xcvr_dir}, 0);
    check_counts();

    // R2: preload while held, then an attempt after release
    for (int i = 0; i < 128; i++) begin
      pl_addr = 7'(i); pl_data = rom_val(i); pl_we = 1;
      ncyc(1);
    end
    pl_we = 0; cpu_hold = 0;
    ncyc(1);
    pl_addr = 7'd4; pl_data = ~rom_val(4); pl_we = 1;
    ncyc(1);
    pl_we = 0;
    mem_read(8'h04, rom_val(4), "R2 preload locked");

    // R3: ROM reads across the half
    mem_read(8'h00, rom_val(0), "R3 rom low");
    mem_read(8'h7F, rom_val(127), "R3 rom top");
    mem_read(8'h55, rom_val(85), "R3 rom mid");

    // R5: RAM writes and readback; write directly after a read
    mem_write(8'h80, 8'hA5);
    mem_write(8'hFF, 8'h3C);
    mem_write(8'h81, 8'h12);
    mem_read(8'h80, 8'hA5, "R5 ram 80");
    mem_read(8'hFF, 8'h3C, "R5 ram ff");

    // R6: write into ROM half is ignored
    mem_write(8'h10, 8'h99);
    mem_read(8'h10, rom_val(16), "R6 rom unchanged");

    // R7/R8/R9: I/O cycles on addresses with known RAM/ROM content
    io_cycle(1'b0, 8'h81, 8'h77);
    chk(io_last_addr == 8'h81 && io_last_data == 8'h77, "R9 io last write",
        {16'd0, io_last_addr, io_last_data}, {16'd0, exp_ioa, exp_iod});
    io_cycle(1'b1, 8'h80, 8'hC3);
    chk(io_last_addr == 8'h80 && io_last_data == 8'hC3, "R9 io last read",
        {16'd0, io_last_addr, io_last_data}, {16'd0, exp_ioa, exp_iod});
    io_cycle(1'b0, 8'h20, 8'h5A);
    mem_read(8'h81, 8'h12, "R7 ram kept");
    mem_read(8'h80, 8'hA5, "R7 ram kept after io rd");
    mem_read(8'h20, rom_val(32), "R7 rom kept");

    ncyc(2);
    check_counts();
    chk(sb.size() == 0, "R3 reads outstanding", sb.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule